// File: doc/BRIEF.md
# Digitally controlled clock period generator

This block produces a pulse train from a fast reference clock, in the way a digitally controlled oscillator would. An 8-bit stage word and a 4-bit divider word set the output period. The three most significant bits of the stage word choose an odd base length between 17 and 31 reference cycles. The divider word stretches that base by a power of two, from 1 up to 512.

Each completed output period yields a single-cycle tick. A roughly half-duty square wave is produced alongside it. Control words are only taken in at a period boundary, so a change of setting never cuts a period short. Other logic uses the tick as a clock enable, and the square wave as a visible slow clock.

Top module: `dco_period_gen`

## Requirements
- R1: The spacing between consecutive ticks is P = (17 + 2·S) · 2^K reference cycles. S is bits [7:5] of the stage word and K is the effective divider exponent.
- R2: With the divider word at 0, stage field values 0 through 7 give periods 17, 19, 21, 23, 25, 27, 29 and 31.
- R3: Divider word values 0 to 9 give K equal to the value, so each step up doubles the period.
- R4: Divider word values 10 to 15 behave exactly as 9, which is a stretch of 512.
- R5: The tick output is high for exactly one reference cycle per period.
- R6: Stage and divider words that change during a period do not alter that period. They take effect from the next period on.
- R7: While reset is high, the tick and the square wave are low. After reset is released, the first tick comes P cycles later. P is computed from the words applied in the last reset cycle.
- R8: Bits [4:0] of the stage word have no effect on the period.
- R9: In every period, the square wave is high for floor(P/2) cycles, starting in the cycle after a tick. It is low in every tick cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; one unit delay per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| stage_ctl_i | input | 8 | Stage word; bits [7:5] choose the base length |
| div_ctl_i | input | 4 | Divider word; power-of-two exponent, saturating at 9 |
| tick_o | output | 1 | One-cycle pulse at the end of each period |
| wave_o | output | 1 | Approximately half-duty square wave, registered |

## Verification
The bench builds the block with its default parameters: a 3-bit stage field, a base of 17 in steps of 2, and saturation at exponent 9. With these values the longest period, 31·512 = 15872 cycles, can be run end to end. This means the saturation codes 10 to 15 are compared against real divide-by-512 periods and not against a scaled-down model. The same build covers the shortest period of 17, odd half-duty splits, and input changes in the middle of a period.

// File: rtl/dco_pkg.sv
package dco_pkg;

  // Longest period any legal setting can produce, for sizing counters.
  function automatic int unsigned dco_max_period(input int unsigned base_min,
                                                 input int unsigned base_step,
                                                 input int unsigned sel_w,
                                                 input int unsigned div_max);
    return (base_min + base_step * ((1 << sel_w) - 1)) << div_max;
  endfunction

endpackage

// File: rtl/dco_base_sel.sv
// Maps the stage-select field to an odd base length in reference cycles.
module dco_base_sel #(
  parameter int SEL_W     = 3,
  parameter int BASE_MIN  = 17,
  parameter int BASE_STEP = 2,
  parameter int BASE_W    = 5
) (
  input  logic [SEL_W-1:0]  sel_i,
  output logic [BASE_W-1:0] base_o
);
  always_comb begin
    base_o = BASE_W'(BASE_MIN) + BASE_W'(BASE_STEP) * BASE_W'(sel_i);
  end
endmodule

// File: rtl/dco_div_clamp.sv
// Saturates the divider exponent at DIV_MAX.
module dco_div_clamp #(
  parameter int DIV_W   = 4,
  parameter int DIV_MAX = 9,
  parameter int AMT_W   = 4
) (
  input  logic [DIV_W-1:0] code_i,
  output logic [AMT_W-1:0] amt_o
);
  localparam logic [DIV_W-1:0] LIMIT = DIV_W'(DIV_MAX);

  always_comb begin
    if (code_i > LIMIT) amt_o = AMT_W'(DIV_MAX);
    else                amt_o = AMT_W'(code_i);
  end
endmodule

// File: rtl/dco_shift.sv
// Logarithmic left shifter: stage i shifts by 2**i when amt bit i is set.
module dco_shift #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 14,
  parameter int AMT_W = 4
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [OUT_W-1:0] val_o
);
  logic [OUT_W-1:0] stage [AMT_W+1];

  assign stage[0] = OUT_W'(val_i);

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    assign stage[i+1] = amt_i[i] ? (stage[i] << (1 << i)) : stage[i];
  end

  assign val_o = stage[AMT_W];
endmodule

// File: rtl/dco_period_gen.sv
module dco_period_gen #(
  parameter int STG_W     = 8,
  parameter int SEL_W     = 3,
  parameter int DIV_W     = 4,
  parameter int DIV_MAX   = 9,
  parameter int BASE_MIN  = 17,
  parameter int BASE_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [STG_W-1:0] stage_ctl_i,
  input  logic [DIV_W-1:0] div_ctl_i,
  output logic             tick_o,
  output logic             wave_o
);
  localparam int BASE_MAX = BASE_MIN + BASE_STEP * ((1 << SEL_W) - 1);
  localparam int BASE_W   = $clog2(BASE_MAX + 1);
  localparam int AMT_W    = $clog2(DIV_MAX + 1);
  localparam int PER_W    = BASE_W + DIV_MAX;

  logic [BASE_W-1:0] base_len;
  logic [AMT_W-1:0]  shift_amt;
  logic [PER_W-1:0]  per_nxt;
  logic [PER_W-1:0]  per_q;
  logic [PER_W-1:0]  cnt_q;
  logic              last_cyc;

  // Only the top SEL_W bits of the stage word matter; the rest are unused.
  dco_base_sel #(
    .SEL_W(SEL_W), .BASE_MIN(BASE_MIN), .BASE_STEP(BASE_STEP), .BASE_W(BASE_W)
  ) base_i (
    .sel_i (stage_ctl_i[STG_W-1 -: SEL_W]),
    .base_o(base_len)
  );

  dco_div_clamp #(
    .DIV_W(DIV_W), .DIV_MAX(DIV_MAX), .AMT_W(AMT_W)
  ) clamp_i (
    .code_i(div_ctl_i),
    .amt_o (shift_amt)
  );

  dco_shift #(
    .IN_W(BASE_W), .OUT_W(PER_W), .AMT_W(AMT_W)
  ) shift_i (
    .val_i(base_len),
    .amt_i(shift_amt),
    .val_o(per_nxt)
  );

  assign last_cyc = (cnt_q == per_q - PER_W'(1));

  // Period length is latched at each boundary (and throughout reset).
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      per_q  <= per_nxt;
      tick_o <= 1'b0;
      wave_o <= 1'b0;
    end else begin
      tick_o <= last_cyc;
      wave_o <= (cnt_q < (per_q >> 1));
      if (last_cyc) begin
        cnt_q <= '0;
        per_q <= per_nxt;
      end else begin
        cnt_q <= cnt_q + PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/dco_period_gen_chk.sv
module dco_period_gen_chk #(
  parameter int SEL_W     = 3,
  parameter int DIV_MAX   = 9,
  parameter int BASE_MIN  = 17,
  parameter int BASE_STEP = 2
) (
  input logic clk_i,
  input logic rst_i,
  input logic tick_o,
  input logic wave_o
);
  localparam int unsigned MAX_PER =
    dco_pkg::dco_max_period(BASE_MIN, BASE_STEP, SEL_W, DIV_MAX);
  localparam int GAP_W = $clog2(MAX_PER + 2) + 1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || tick_o)              gap_q <= '0;
    else if (gap_q <= GAP_W'(MAX_PER)) gap_q <= gap_q + GAP_W'(1);
  end

  // R5: a tick never lasts two cycles
  a_r5_tick_single: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

  // R7: reset silences both outputs
  a_r7_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (!tick_o && !wave_o));

  // R9: the square wave is low while the tick is high
  a_r9_wave_low_at_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |-> !wave_o);

  // R1: ticks are never closer than the shortest base length
  a_r1_min_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |-> (gap_q >= GAP_W'(BASE_MIN - 1)));

  // R4: no period exceeds the saturated maximum
  a_r4_max_spacing: assert property (@(posedge clk_i) disable iff (rst_i)
    gap_q <= GAP_W'(MAX_PER));
endmodule

bind dco_period_gen dco_period_gen_chk #(
  .SEL_W(SEL_W), .DIV_MAX(DIV_MAX), .BASE_MIN(BASE_MIN), .BASE_STEP(BASE_STEP)
) chk_i (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .tick_o(tick_o),
  .wave_o(wave_o)
);

// File: tb/dco_period_gen_tb_top.sv
module dco_period_gen_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 190000;
  localparam int  NVEC       = 10;
  localparam int  MEAS_LIMIT = 20000;

  // {stage word, divider word, expected period}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 4'd0,  20'd17},     // R2 shortest base
    {8'hE0, 4'd0,  20'd31},     // R2 longest base
    {8'h55, 4'd0,  20'd21},     // R8 low bits set, sel=2
    {8'hA0, 4'd3,  20'd216},    // R3 27*8
    {8'h60, 4'd1,  20'd46},     // R3 23*2
    {8'h80, 4'd5,  20'd800},    // R3 25*32
    {8'h00, 4'd9,  20'd8704},   // R3 17*512
    {8'hFF, 4'd9,  20'd15872},  // R3 31*512, low bits set
    {8'h20, 4'd12, 20'd9728},   // R4 saturates: 19*512
    {8'hC0, 4'd15, 20'd14848}   // R4 saturates: 29*512
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] stg = 8'h00;
  logic [3:0] dv  = 4'd0;
  logic       tick;
  logic       wave;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dco_period_gen dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .stage_ctl_i(stg),
    .div_ctl_i  (dv),
    .tick_o     (tick),
    .wave_o     (wave)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reset with given words; inputs held for two cycles in reset, released at a negedge.
  task automatic do_reset(input logic [7:0] s, input logic [3:0] d);
    @(negedge clk);
    rst = 1'b1; stg = s; dv = d;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Count samples up to and including the next tick; optionally change words at sample chg_at.
  task automatic measure(input int chg_at, input logic [7:0] s, input logic [3:0] d,
                         output int n, output int highs, output bit first_tick);
    n = 0; highs = 0; first_tick = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (wave) highs++;
      if (n == 1) first_tick = tick;
      if (chg_at != 0 && n == chg_at) begin stg = s; dv = d; end
    end while (!tick && n < MEAS_LIMIT);
  endtask

  initial begin
    int n, h;
    bit t1;
    // R7: reset state
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R7 tick in reset", int'(tick), 0);
    check(wave == 1'b0, "R7 wave in reset", int'(wave), 0);

    // Table walk: first period after reset, then one steady period
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0]  vs = VEC[i][31:24];
      logic [3:0]  vd = VEC[i][23:20];
      int          vp = int'(VEC[i][19:0]);
      do_reset(vs, vd);
      measure(0, 8'h00, 4'd0, n, h, t1);
      check(n == vp, $sformatf("R7 R1 first period row %0d", i), n, vp);
      check(h == vp/2, $sformatf("R9 high count row %0d", i), h, vp/2);
      measure(0, 8'h00, 4'd0, n, h, t1);
      check(n == vp, $sformatf("R1 R2 R3 R4 R8 period row %0d", i), n, vp);
      check(t1 == 1'b0, $sformatf("R5 tick width row %0d", i), int'(t1), 0);
      check(h == vp/2, $sformatf("R9 steady high count row %0d", i), h, vp/2);
    end

    // R6: mid-period change waits for the boundary (17 then 31*4)
    do_reset(8'h00, 4'd0);
    measure(5, 8'hE0, 4'd2, n, h, t1);
    check(n == 17, "R6 current period kept", n, 17);
    measure(0, 8'h00, 4'd0, n, h, t1);
    check(n == 124, "R6 new period after boundary", n, 124);

    // R8: changing only the low stage bits mid-period changes nothing (21*2)
    do_reset(8'h40, 4'd1);
    measure(3, 8'h5F, 4'd1, n, h, t1);
    check(n == 42, "R8 low bits mid-period", n, 42);
    measure(0, 8'h00, 4'd0, n, h, t1);
    check(n == 42, "R8 low bits next period", n, 42);

    // R7: reset mid-period, words changed in last reset cycle are used (19)
    do_reset(8'h00, 4'd0);
    repeat (7) @(negedge clk);
    rst = 1'b1; stg = 8'hE0; dv = 4'd3;
    @(negedge clk);
    check(tick == 1'b0 && wave == 1'b0, "R7 outputs cleared mid-period",
          int'({tick, wave}), 0);
    stg = 8'h20; dv = 4'd0;
    @(negedge clk);
    rst = 1'b0;
    measure(0, 8'h00, 4'd0, n, h, t1);
    check(n == 19, "R7 release values used", n, 19);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule